// File: doc/BRIEF.md
# Byte Load Address Generator

This block sits in the address stage of a 32-bit load/store pipeline. It takes the instruction word of a byte load along with the contents of the base address register. Some modes use a register pair. For those, it also takes the odd partner register, which packs a 16-bit length or increment in its upper half and a 16-bit index in its lower half. From these inputs it works out the addressing mode, the effective address and the destination data register. It also decides whether the loaded byte is sign- or zero-extended. When the mode calls for it, it produces an address-register update with its target number and value.

The block is purely combinational. The byte returned by memory is fed back into `ld_byte`, and the block delivers it widened to 32 bits on `ld_data`. Encodings it does not recognise raise `illegal`. In that case every side effect is suppressed.

Top module: `byte_ld_agu`

## Requirements
- R1: For every legal encoding, `dst_reg` equals instruction bits [11:8].
- R2: Post-increment (`instr[7:0]`=0x09, `instr[27:22]`=0x00) gives `eff_addr` = base. It updates register `instr[15:12]` with base + sign-extended off10. Here off10 = {instr[31:28], instr[21:16]}. The byte is sign-extended.
- R3: Pre-increment (0x09 / 0x10) gives `eff_addr` = base + sign-extended off10. It writes that same address to register `instr[15:12]`. The byte is sign-extended.
- R4: Short offset (0x09 / 0x21) gives `eff_addr` = base + sign-extended off10. There is no update and the byte is zero-extended.
- R5: Long offset (opcode 0x79, any bits [27:22]) gives `eff_addr` = base + sign-extended off16. Here off16 = {instr[27:22], instr[31:28], instr[21:16]}. There is no update and the byte is sign-extended.
- R6: Absolute (opcode 0x05 with `instr[27:26]`=01) assembles off18 = {instr[15:12], instr[25:22], instr[31:28], instr[21:16]}. It gives `eff_addr` = {off18[17:14], 14'b0, off18[13:0]}. There is no update and the byte is zero-extended.
- R7: Circular (0x29 / 0x12) reads index = pair[15:0] and length = pair[31:16]. It gives `eff_addr` = base + index. It computes s = index + sign-extended off10. The new index is s + length when s is negative, and s mod length otherwise. It writes {length, new index[15:0]} to register `instr[15:12]`+1. The byte is sign-extended.
- R8: In circular mode with length 0 and s not negative, the new index is s with no wrap.
- R9: Bit-reverse (0x29 / 0x01) reads index = pair[15:0] and increment = pair[31:16]. It gives `eff_addr` = base + index and zero-extends the byte. It writes {increment, rev(rev(index) + rev(increment))} to register `instr[15:12]`+1, where rev mirrors 16 bits.
- R10: `ld_data` is `ld_byte` extended to 32 bits. Extension is signed when `sign_sel`=1 and zero when `sign_sel`=0.
- R11: `illegal` is 1 for any other encoding, and for a pair mode with odd `instr[15:12]`. When `illegal` is 1, `upd_en`=0 and `eff_addr`=0.
- R12: `upd_en` is 1 only for post-increment, pre-increment, circular and bit-reverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Byte-load instruction word |
| base_a | input | 32 | Base address register contents |
| pair_hi | input | 32 | Odd partner register (length/increment, index) |
| ld_byte | input | 8 | Byte returned by memory |
| eff_addr | output | 32 | Effective address |
| sign_sel | output | 1 | 1 = sign-extend, 0 = zero-extend |
| dst_reg | output | 4 | Destination data register number |
| upd_en | output | 1 | Address register update enable |
| upd_reg | output | 4 | Address register to update |
| upd_val | output | 32 | Update value |
| ld_data | output | 32 | Extended load data |
| illegal | output | 1 | Unrecognised encoding |

## Verification
The block has no parameters. The bench therefore builds it as is, and the fixed 32-bit encoding puts every addressing mode within reach from the instruction word alone. Random words drawn per mode reach both sign cases of the offsets and the full range of index and length. Directed vectors pin the negative circular wrap, the zero-length case, the modulo fold, odd pair registers and known bit-reverse steps.

// File: rtl/byte_ld_agu.sv
module byte_ld_agu (
  input  logic [31:0] instr,
  input  logic [31:0] base_a,
  input  logic [31:0] pair_hi,
  input  logic [7:0]  ld_byte,
  output logic [31:0] eff_addr,
  output logic        sign_sel,
  output logic [3:0]  dst_reg,
  output logic        upd_en,
  output logic [3:0]  upd_reg,
  output logic [31:0] upd_val,
  output logic [31:0] ld_data,
  output logic        illegal
);
  typedef enum logic [2:0] {M_ILL, M_POST, M_PRE, M_SHORT, M_LONG, M_ABS, M_BREV, M_CIRC} mode_e;

  wire [7:0]  opc   = instr[7:0];
  wire [5:0]  sub   = instr[27:22];
  wire [3:0]  breg  = instr[15:12];
  wire [9:0]  off10 = {instr[31:28], instr[21:16]};
  wire [15:0] off16 = {instr[27:22], instr[31:28], instr[21:16]};
  wire [17:0] off18 = {instr[15:12], instr[25:22], instr[31:28], instr[21:16]};
  wire [31:0] sx10  = {{22{off10[9]}}, off10};
  wire [31:0] sx16  = {{16{off16[15]}}, off16};
  wire [15:0] idx   = pair_hi[15:0];
  wire [15:0] len   = pair_hi[31:16];

  mode_e mode;
  always_comb begin
    mode = M_ILL;
    case (opc)
      8'h09: case (sub)
        6'h00: mode = M_POST;
        6'h10: mode = M_PRE;
        6'h21: mode = M_SHORT;
        default: mode = M_ILL;
      endcase
      8'h79: mode = M_LONG;
      8'h05: if (instr[27:26] == 2'b01) mode = M_ABS;
      8'h29: if (!breg[0]) begin
        if (sub == 6'h01) mode = M_BREV;
        else if (sub == 6'h12) mode = M_CIRC;
      end
      default: mode = M_ILL;
    endcase
  end

  function automatic logic [15:0] mirror(input logic [15:0] v);
    for (int i = 0; i < 16; i++) mirror[i] = v[15-i];
  endfunction

  logic signed [17:0] csum;
  logic [16:0]        cmod;
  logic [15:0]        cnew;
  always_comb begin
    csum = $signed({2'b00, idx}) + $signed(sx10[17:0]);
    cmod = csum[16:0] % {1'b0, len};
    if (csum < 0)       cnew = csum[15:0] + len;
    else if (len == 0)  cnew = csum[15:0];
    else                cnew = cmod[15:0];
  end

  wire [15:0] bnew = mirror(mirror(idx) + mirror(len));

  always_comb begin
    eff_addr = '0;
    upd_val  = '0;
    sign_sel = 1'b0;
    upd_en   = 1'b0;
    upd_reg  = breg;
    case (mode)
      M_POST:  begin eff_addr = base_a;        upd_val = base_a + sx10; sign_sel = 1'b1; upd_en = 1'b1; end
      M_PRE:   begin eff_addr = base_a + sx10; upd_val = base_a + sx10; sign_sel = 1'b1; upd_en = 1'b1; end
      M_SHORT: eff_addr = base_a + sx10;
      M_LONG:  begin eff_addr = base_a + sx16; sign_sel = 1'b1; end
      M_ABS:   eff_addr = {off18[17:14], 14'b0, off18[13:0]};
      M_CIRC:  begin eff_addr = base_a + {16'b0, idx}; upd_val = {len, cnew}; sign_sel = 1'b1;
                     upd_en = 1'b1; upd_reg = breg | 4'd1; end
      M_BREV:  begin eff_addr = base_a + {16'b0, idx}; upd_val = {len, bnew};
                     upd_en = 1'b1; upd_reg = breg | 4'd1; end
      default: ;
    endcase
  end

  assign illegal = (mode == M_ILL);
  assign dst_reg = instr[11:8];
  assign ld_data = {{24{sign_sel & ld_byte[7]}}, ld_byte};

  always_comb begin
    if (illegal) assert_ill_quiet_R11: assert (!upd_en && eff_addr == 32'd0);
    if (mode == M_POST) assert_post_ea_R2: assert (eff_addr == base_a && upd_reg == breg);
    if (mode == M_PRE) assert_pre_wb_R3: assert (upd_val == eff_addr);
    if (upd_en) assert_upd_legal_R12: assert (!illegal && mode != M_SHORT && mode != M_LONG && mode != M_ABS);
    assert_ext_R10: assert (ld_data[7:0] == ld_byte && (ld_data[31:8] == 24'd0 || ld_data[31:8] == 24'hFFFFFF));
    if (mode == M_CIRC) assert_circ_len_R7: assert (upd_val[31:16] == pair_hi[31:16] && upd_reg[0]);
  end
endmodule

// File: tb/byte_ld_agu_test.sv
module byte_ld_agu_test;
  logic clk = 0;
  logic rst_n = 0;
  always #2.5 clk = ~clk;

  logic [31:0] instr = 0, base_a = 0, pair_hi = 0;
  logic [7:0]  ld_byte = 0;
  logic [31:0] eff_addr, upd_val, ld_data;
  logic [3:0]  dst_reg, upd_reg;
  logic        sign_sel, upd_en, illegal;

  byte_ld_agu uut (.instr, .base_a, .pair_hi, .ld_byte, .eff_addr, .sign_sel,
                   .dst_reg, .upd_en, .upd_reg, .upd_val, .ld_data, .illegal);

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (instr=%h)", tag, act, exp, instr);
    end
  endtask

  function automatic logic [15:0] rev16(input logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[15-i] = v[i];
    return r;
  endfunction

  function automatic logic [31:0] mk(input logic [7:0] op, input logic [5:0] sub,
                                     input logic [3:0] b, input logic [3:0] a, input logic [9:0] o);
    return {o[9:6], sub, o[5:0], b, a, op};
  endfunction

  task automatic apply_and_check;
    int k, s, ix, ln, o;
    logic [31:0] e_ea, e_uv;
    logic e_ss, e_ue, e_il;
    logic [3:0] e_ur;
    string tg;
    k = 0;
    o = int'({{22{instr[31]}}, instr[31:28], instr[21:16]});
    ix = int'(pair_hi[15:0]);
    ln = int'(pair_hi[31:16]);
    e_ea = 0; e_uv = 0; e_ss = 0; e_ue = 0; e_il = 0; e_ur = instr[15:12]; tg = "R11";
    if (instr[7:0] == 8'h09 && instr[27:22] == 6'h00) begin
      tg = "R2"; e_ea = base_a; e_uv = base_a + o; e_ss = 1; e_ue = 1;
    end else if (instr[7:0] == 8'h09 && instr[27:22] == 6'h10) begin
      tg = "R3"; e_ea = base_a + o; e_uv = e_ea; e_ss = 1; e_ue = 1;
    end else if (instr[7:0] == 8'h09 && instr[27:22] == 6'h21) begin
      tg = "R4"; e_ea = base_a + o;
    end else if (instr[7:0] == 8'h79) begin
      tg = "R5"; e_ea = base_a + {{16{instr[27]}}, instr[27:22], instr[31:28], instr[21:16]}; e_ss = 1;
    end else if (instr[7:0] == 8'h05 && instr[27:26] == 2'b01) begin
      tg = "R6"; e_ea = {instr[15:12], 14'd0, instr[25:22], instr[31:28], instr[21:16]};
    end else if (instr[7:0] == 8'h29 && instr[27:22] == 6'h12 && !instr[12]) begin
      tg = "R7"; e_ea = base_a + ix; e_ss = 1; e_ue = 1; e_ur = instr[15:12] + 1;
      s = ix + o;
      if (s < 0) k = s + ln; else if (ln == 0) k = s; else k = s % ln;
      e_uv = {pair_hi[31:16], k[15:0]};
    end else if (instr[7:0] == 8'h29 && instr[27:22] == 6'h01 && !instr[12]) begin
      tg = "R9"; e_ea = base_a + ix; e_ue = 1; e_ur = instr[15:12] + 1;
      e_uv = {pair_hi[31:16], rev16(rev16(pair_hi[15:0]) + rev16(pair_hi[31:16]))};
    end else e_il = 1;
    @(negedge clk);
    chk({tg, " illegal R11"}, {31'd0, illegal}, {31'd0, e_il});
    chk({tg, " ea"}, eff_addr, e_ea);
    chk({tg, " upd_en R12"}, {31'd0, upd_en}, {31'd0, e_ue});
    chk({tg, " sign_sel"}, {31'd0, sign_sel}, {31'd0, e_ss});
    chk("R10 ld_data", ld_data, {{24{e_ss & ld_byte[7]}}, ld_byte});
    if (!e_il) chk("R1 dst_reg", {28'd0, dst_reg}, {28'd0, instr[11:8]});
    if (e_ue) begin
      chk({tg, " upd_reg"}, {28'd0, upd_reg}, {28'd0, e_ur});
      chk({tg, " upd_val"}, upd_val, e_uv);
    end
    @(posedge clk);
  endtask

  task automatic drive(input logic [31:0] i, input logic [31:0] b, input logic [31:0] p, input logic [7:0] d);
    instr = i; base_a = b; pair_hi = p; ld_byte = d;
    apply_and_check();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(posedge clk);
    rst_n = 1;
    // idle word: opcode 0 is illegal (R11)
    drive(32'h0, 32'h0, 32'h0, 8'h00);
    // directed corners
    drive(mk(8'h09, 6'h00, 4'd3, 4'd5, 10'h3FF), 32'h1000, 0, 8'h80);       // R2 negative offset
    drive(mk(8'h09, 6'h10, 4'd2, 4'd1, 10'h1FF), 32'hFFFF_FF00, 0, 8'h7F);  // R3 carry across
    drive(mk(8'h09, 6'h21, 4'd2, 4'd1, 10'h200), 32'h10, 0, 8'hF0);         // R4 zero-extend
    drive({4'hF, 6'h3F, 6'h3F, 4'd1, 4'd2, 8'h79}, 32'h2000, 0, 8'h81);     // R5 off16 = -1
    drive({4'h5, 2'b01, 4'hA, 6'h2B, 4'hC, 4'd7, 8'h05}, 0, 0, 8'hFF);       // R6 segment layout
    drive({4'h5, 2'b10, 4'hA, 6'h2B, 4'hC, 4'd7, 8'h05}, 0, 0, 8'hFF);       // R11 bad abs sub
    drive(mk(8'h29, 6'h12, 4'd4, 4'd0, 10'h3F0), 32'h4000, {16'd20, 16'd3}, 8'h90); // R7 negative wrap
    drive(mk(8'h29, 6'h12, 4'd4, 4'd0, 10'd10), 32'h4000, {16'd8, 16'd5}, 8'h10);   // R7 modulo fold
    drive(mk(8'h29, 6'h12, 4'd6, 4'd0, 10'd7), 32'h0, {16'd0, 16'd100}, 8'h10);     // R8 zero length
    drive(mk(8'h29, 6'h12, 4'd5, 4'd0, 10'd7), 32'h0, {16'd8, 16'd1}, 8'h10);       // R11 odd pair
    drive(mk(8'h29, 6'h01, 4'd8, 4'd0, 10'd0), 32'h100, {16'h8000, 16'h8000}, 8'h01); // R9 step
    drive(mk(8'h29, 6'h01, 4'd9, 4'd0, 10'd0), 32'h100, {16'h8000, 16'h0}, 8'h01);    // R11 odd pair
    drive(mk(8'h09, 6'h3F, 4'd1, 4'd1, 10'd0), 32'h100, 0, 8'h01);                    // R11 bad sub
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] w;
      int kind;
      w = $urandom;
      kind = int'($urandom % 9);
      case (kind)
        0: w = {w[31:28], 6'h00, w[21:8], 8'h09};
        1: w = {w[31:28], 6'h10, w[21:8], 8'h09};
        2: w = {w[31:28], 6'h21, w[21:8], 8'h09};
        3: w = {w[31:8], 8'h79};
        4: w = {w[31:28], 2'b01, w[25:8], 8'h05};
        5: w = {w[31:28], 6'h12, w[21:8], 8'h29};
        6: w = {w[31:28], 6'h01, w[21:8], 8'h29};
        7: w = {w[31:8], 8'h29};
        default: ;
      endcase
      drive(w, $urandom, {($urandom % 4 == 0) ? 16'd0 : 16'($urandom), 16'($urandom)}, 8'($urandom));
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule